// File: doc/BRIEF.md
# Flash Hardware Reset Sequencer

This block is the device-side handler for the active-low hardware reset pin of a flash-style memory. It synchronises the pin and measures how long it stays low. A pulse shorter than the minimum width is dropped. A long enough pulse aborts whatever program or erase the command engine is running and holds that engine until a fixed delay has elapsed from the first low sample. The engine then stands in read mode again.

While the pin is low, the block keeps the part in standby. The data drivers are off and the ready/busy output is marked as not meaningful. After the pin returns high, reads stay blocked for a short recovery window. If the pin is released before the return to read mode has finished, the full delay still runs before the recovery window starts. An abort that hits a running program or erase raises a sticky corruption flag, together with the sector and the kind of operation that was lost.

The synchronous power-up reset puts the block straight into read mode with reads allowed. All intervals are given in nanoseconds and turned into clock counts from the clock period parameter.

Top module: `flash_rst_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `sm_hold` and `sm_abort` are 0, `dq_oe` is 1, `standby` is 0 and `corrupt_flag` is 0. This holds even if `rst` arrives in the middle of a hardware reset.
- R2: Three clock cycles after `rst_pin_n` goes low, and for as long as it stays low, `standby` is 1, `rdy_valid` is 0 and `dq_oe` is 0.
- R3: A low pulse on `rst_pin_n` shorter than MIN_LOW_NS (ceil(MIN_LOW_NS/clock period) cycles; exactly one cycle fewer is enough) never raises `sm_abort` or `sm_hold` and leaves the corruption outputs unchanged.
- R4: A low pulse of at least the minimum width, exactly the minimum included, raises `sm_abort` for exactly one cycle, and `sm_hold` is 1 in that cycle.
- R5: `sm_hold` stays 1 until RD_DELAY_NS worth of cycles after the first synchronised low sample and then falls, even if the pin is still low. `dq_oe` stays 0 while the pin is low.
- R6: After the pin returns high once read mode has been reached, `dq_oe` stays 0 for RECOV_NS worth of cycles (plus the two-cycle synchroniser) and then returns to 1.
- R7: If the pin is released before the read-mode delay has run out, `sm_hold` still runs for the full delay. `dq_oe` stays 0 until the delay and then the recovery window have both passed.
- R8: At the `sm_abort` cycle, if `op_kind` is 1 (program), 3 (program inside a suspended erase) or 2 (erase), `corrupt_flag` becomes 1, `corrupt_sector` takes `op_sector`, and `corrupt_erase` becomes 1 for kind 2 and 0 otherwise. Kind 0 (idle) leaves all three outputs unchanged.
- R9: A new low pulse during the recovery window starts a fresh qualification, and if it is long enough it aborts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| rst_pin_n | input | 1 | Asynchronous active-low hardware reset pin |
| op_kind | input | 2 | Operation running in the command engine: 0 idle, 1 program, 2 erase, 3 program in suspended erase |
| op_sector | input | SECT_W | Sector targeted by the running operation |
| standby | output | 1 | Device in standby because the reset pin is low |
| rdy_valid | output | 1 | 0 when the ready/busy output is a don't-care |
| dq_oe | output | 1 | Data outputs driven and reads allowed; 0 means high impedance |
| sm_abort | output | 1 | One-cycle abort command to the command engine |
| sm_hold | output | 1 | Command engine held in reset, returning to read mode |
| corrupt_flag | output | 1 | Sticky flag: an operation was cut off by a reset |
| corrupt_erase | output | 1 | The lost operation was an erase |
| corrupt_sector | output | SECT_W | Sector of the lost operation |

## Verification
Two functions can fall in the same cycle. A pin release (or a new falling edge) can land while the read-mode delay is still counting, so release handling and the delay compete for the next state. The bench provokes this in three ways: it releases the pin a few cycles after qualification, it holds the pin past the delay, and it drops the pin again inside the recovery window. It judges the outcome only at the ports: `sm_hold` must last the full delay, `dq_oe` must stay off through the whole recovery window, and a second abort must appear. The latch of the operation kind at the abort cycle is checked against a table of pulse widths and operation kinds, with the widths on both sides of the minimum.

// File: rtl/flash_rst_pkg.sv
package flash_rst_pkg;
  typedef enum logic [1:0] {
    OP_IDLE      = 2'd0,
    OP_PROG      = 2'd1,
    OP_ERASE     = 2'd2,
    OP_SUSP_PROG = 2'd3
  } op_kind_e;

  typedef enum logic [2:0] {
    ST_READ  = 3'd0,
    ST_QUAL  = 3'd1,
    ST_ABORT = 3'd2,
    ST_HELD  = 3'd3,
    ST_LOCK  = 3'd4
  } rst_state_e;

  function automatic int ns_to_cyc(input int ns, input int period_ps);
    return (ns * 1000 + period_ps - 1) / period_ps;
  endfunction
endpackage

// File: rtl/flash_rst_sync.sv
module flash_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic low_s
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= ~pin_n;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], ~pin_n};
      end
    end
  endgenerate

  assign low_s = sh[STAGES-1];
endmodule

// File: rtl/flash_rst_fsm.sv
module flash_rst_fsm
  import flash_rst_pkg::*;
#(
  parameter int MIN_LOW_CYC  = 50,
  parameter int RD_DELAY_CYC = 2000,
  parameter int RECOV_CYC    = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic low_s,
  output logic sm_abort,
  output logic sm_hold,
  output logic dq_oe
);
  localparam int MAXC = (RD_DELAY_CYC > RECOV_CYC) ? RD_DELAY_CYC : RECOV_CYC;
  localparam int CW   = $clog2(MAXC + 2);

  rst_state_e    state;
  logic [CW-1:0] cnt;
  logic          abort_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_READ;
      cnt     <= '0;
      abort_q <= 1'b0;
    end else begin
      abort_q <= 1'b0;
      case (state)
        ST_READ: if (low_s) begin
          state <= ST_QUAL;
          cnt   <= CW'(1);
        end
        ST_QUAL: begin
          if (!low_s) begin
            state <= ST_READ;
          end else begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(MIN_LOW_CYC - 1)) begin
              state   <= ST_ABORT;
              abort_q <= 1'b1;
            end
          end
        end
        ST_ABORT: begin
          if (cnt == CW'(RD_DELAY_CYC)) begin
            state <= low_s ? ST_HELD : ST_LOCK;
            cnt   <= CW'(1);
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HELD: if (!low_s) begin
          state <= ST_LOCK;
          cnt   <= CW'(1);
        end
        ST_LOCK: begin
          if (low_s) begin
            state <= ST_QUAL;
            cnt   <= CW'(1);
          end else if (cnt == CW'(RECOV_CYC)) begin
            state <= ST_READ;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_READ;
      endcase
    end
  end

  assign sm_abort = abort_q;
  assign sm_hold  = (state == ST_ABORT);
  assign dq_oe    = (state == ST_READ) && !low_s;

  // R4
  abort_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    sm_abort |=> !sm_abort);
  // R4
  abort_in_hold_chk: assert property (@(posedge clk) disable iff (rst)
    sm_abort |-> sm_hold);
  // R5
  hold_blocks_read_chk: assert property (@(posedge clk) disable iff (rst)
    sm_hold |-> !dq_oe);
  // R6
  lock_after_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sm_hold) |-> !dq_oe);
  // R3
  short_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_QUAL && !low_s) |=> !sm_hold);
endmodule

// File: rtl/flash_rst_corrupt.sv
module flash_rst_corrupt
  import flash_rst_pkg::*;
#(
  parameter int SECT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic [1:0]        op_kind,
  input  logic [SECT_W-1:0] op_sector,
  output logic              flag,
  output logic              erase,
  output logic [SECT_W-1:0] sector
);
  op_kind_e kind;
  assign kind = op_kind_e'(op_kind);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag   <= 1'b0;
      erase  <= 1'b0;
      sector <= '0;
    end else if (abort && kind != OP_IDLE) begin
      flag   <= 1'b1;
      erase  <= (kind == OP_ERASE);
      sector <= op_sector;
    end
  end

  // R8
  flag_needs_abort_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(abort));
  // R8
  sector_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(abort) |-> $stable(sector));
endmodule

// File: rtl/flash_rst_seq.sv
module flash_rst_seq
  import flash_rst_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 10000,
  parameter int MIN_LOW_NS    = 500,
  parameter int RD_DELAY_NS   = 20000,
  parameter int RECOV_NS      = 50,
  parameter int SYNC_STAGES   = 2,
  parameter int SECT_W        = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rst_pin_n,
  input  logic [1:0]        op_kind,
  input  logic [SECT_W-1:0] op_sector,
  output logic              standby,
  output logic              rdy_valid,
  output logic              dq_oe,
  output logic              sm_abort,
  output logic              sm_hold,
  output logic              corrupt_flag,
  output logic              corrupt_erase,
  output logic [SECT_W-1:0] corrupt_sector
);
  localparam int MIN_LOW_CYC  = ns_to_cyc(MIN_LOW_NS, CLK_PERIOD_PS);
  localparam int RD_DELAY_CYC = ns_to_cyc(RD_DELAY_NS, CLK_PERIOD_PS);
  localparam int RECOV_CYC    = ns_to_cyc(RECOV_NS, CLK_PERIOD_PS);

  logic low_s;

  flash_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_n(rst_pin_n), .low_s(low_s)
  );

  flash_rst_fsm #(
    .MIN_LOW_CYC(MIN_LOW_CYC), .RD_DELAY_CYC(RD_DELAY_CYC), .RECOV_CYC(RECOV_CYC)
  ) u_fsm (
    .clk(clk), .rst(rst), .low_s(low_s),
    .sm_abort(sm_abort), .sm_hold(sm_hold), .dq_oe(dq_oe)
  );

  flash_rst_corrupt #(.SECT_W(SECT_W)) u_corrupt (
    .clk(clk), .rst(rst), .abort(sm_abort), .op_kind(op_kind), .op_sector(op_sector),
    .flag(corrupt_flag), .erase(corrupt_erase), .sector(corrupt_sector)
  );

  assign standby   = low_s;
  assign rdy_valid = !low_s;

  // R2
  standby_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    standby |-> !dq_oe);
  // R1
  powerup_read_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dq_oe && !sm_hold && !corrupt_flag));
endmodule

// File: tb/flash_rst_seq_bench.sv
module flash_rst_seq_bench;
  localparam int MIN   = 50;
  localparam int DELAY = 2000;
  localparam int RECOV = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin_n = 1'b1;
  logic [1:0] kind = 2'd0;
  logic [3:0] sect = 4'd0;
  logic standby, rdy_valid, dq_oe, sm_abort, sm_hold, cflag, cerase;
  logic [3:0] csect;

  int checks = 0, errors = 0, aborts = 0, cycles = 0;

  always #5 clk = ~clk;

  flash_rst_seq u_flash_rst_seq (
    .clk(clk), .rst(rst), .rst_pin_n(pin_n), .op_kind(kind), .op_sector(sect),
    .standby(standby), .rdy_valid(rdy_valid), .dq_oe(dq_oe), .sm_abort(sm_abort),
    .sm_hold(sm_hold), .corrupt_flag(cflag), .corrupt_erase(cerase), .corrupt_sector(csect)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (sm_abort) aborts <= aborts + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input int len);
    @(negedge clk) pin_n = 1'b0;
    repeat (len) @(negedge clk);
    pin_n = 1'b1;
  endtask

  typedef struct packed {
    logic [15:0] len;
    logic [1:0]  kind;
    logic [3:0]  sect;
    logic        ab;
    logic        flag;
    logic        erase;
    logic [3:0]  esect;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'(MIN-1),   2'd1, 4'd3, 1'b0, 1'b0, 1'b0, 4'd0},
    '{16'd3,        2'd2, 4'd7, 1'b0, 1'b0, 1'b0, 4'd0},
    '{16'(MIN),     2'd0, 4'd1, 1'b1, 1'b0, 1'b0, 4'd0},
    '{16'(MIN+20),  2'd2, 4'd5, 1'b1, 1'b1, 1'b1, 4'd5},
    '{16'(MIN),     2'd0, 4'd9, 1'b1, 1'b1, 1'b1, 4'd5},
    '{16'(2*MIN),   2'd3, 4'd2, 1'b1, 1'b1, 1'b0, 4'd2}
  };

  initial begin
    int a0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 dq_oe", dq_oe, 1);
    chk("R1 sm_hold", sm_hold, 0);
    chk("R1 standby", standby, 0);
    chk("R1 corrupt_flag", cflag, 0);

    for (int i = 0; i < 6; i++) begin
      kind = VECS[i].kind;
      sect = VECS[i].sect;
      a0 = aborts;
      pulse(int'(VECS[i].len));
      repeat (DELAY + RECOV + 40) @(negedge clk);
      chk(VECS[i].ab ? "R4 abort count" : "R3 short pulse ignored", aborts - a0, VECS[i].ab);
      chk("R8 corrupt_flag", cflag, VECS[i].flag);
      chk("R8 corrupt_erase", cerase, VECS[i].erase);
      chk("R8 corrupt_sector", csect, VECS[i].esect);
      chk("R6 reads restored", dq_oe, 1);
    end

    // R2 / R5 / R6: pin held past the delay
    kind = 2'd0;
    @(negedge clk) pin_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 standby", standby, 1);
    chk("R2 rdy_valid", rdy_valid, 0);
    chk("R2 dq_oe", dq_oe, 0);
    repeat (DELAY - 100) @(negedge clk);
    chk("R5 hold before delay", sm_hold, 1);
    repeat (110) @(negedge clk);
    chk("R5 hold released with pin low", sm_hold, 0);
    chk("R5 dq_oe while pin low", dq_oe, 0);
    pin_n = 1'b1;
    repeat (RECOV) @(negedge clk);
    chk("R6 lockout", dq_oe, 0);
    repeat (5) @(negedge clk);
    chk("R6 reads after lockout", dq_oe, 1);

    // R7: early release
    pulse(MIN + 5);
    repeat (300) @(negedge clk);
    chk("R7 hold continues", sm_hold, 1);
    chk("R7 reads blocked", dq_oe, 0);
    repeat (DELAY) @(negedge clk);
    chk("R7 reads after delay", dq_oe, 1);

    // R9: new pulse inside the lockout window
    @(negedge clk) pin_n = 1'b0;
    repeat (DELAY + 20) @(negedge clk);
    pin_n = 1'b1;
    repeat (2) @(negedge clk);
    a0 = aborts;
    pulse(MIN + 2);
    repeat (10) @(negedge clk);
    chk("R9 re-abort", aborts - a0, 1);
    chk("R9 hold again", sm_hold, 1);
    repeat (DELAY + RECOV + 40) @(negedge clk);
    chk("R9 reads restored", dq_oe, 1);

    // R1: power-up reset during a hold with an erase running
    kind = 2'd2;
    sect = 4'd9;
    @(negedge clk) pin_n = 1'b0;
    repeat (MIN + 50) @(negedge clk);
    chk("R8 flag before power reset", cflag, 1);
    chk("R5 hold before power reset", sm_hold, 1);
    pin_n = 1'b1;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 hold cleared", sm_hold, 0);
    chk("R1 dq_oe", dq_oe, 1);
    chk("R1 flag cleared", cflag, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++;
    errors++;
    $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule